// File: doc/BRIEF.md
# Frame-Triggered Register Write Sequencer

This block sits inline on a video packet stream that uses a valid/ready handshake with start-of-packet and end-of-packet markers. Accepted beats pass from the input side to the output side unchanged. Software configures it through a 32-bit register file addressed by word offset. The file holds a run bit, an interrupt enable, a trigger-disable bit, a write count and ten target-address/data pairs.

When a frame begins (an accepted start-of-packet beat) and the trigger is armed, the block copies the programmed pairs and the count into shadow storage. It then plays them out as single memory-mapped writes on a master port that honours a wait signal. It can disarm its own trigger each time it fires, so that software must re-arm it before the next frame. A sticky completion flag, cleared by writing one, drives an interrupt output through the enable bit.

Top module: `frame_wr_sequencer`

## Requirements
- R1: While the stream gate is open, `m_data`, `m_sop` and `m_eop` equal the input fields, `m_valid` equals `s_valid`, and `s_ready` equals `m_ready`.
- R2: With Go (offset 0 bit 0) at 0 between packets, `s_ready` and `m_valid` are 0. A packet whose start beat was already accepted keeps flowing until its end beat, even if Go is cleared.
- R3: The register map is as follows. Offset 0 holds Go in bit 0 and the interrupt enable in bit 1. Offset 1 is read-only and holds busy in bit 0. Offset 2 holds the completion flag in bit 1. Offset 3 holds the trigger disable in bit 0. Offset 4 holds the write count as a full word. Offset 5+2k holds the address of pair k and offset 6+2k its data, for k = 0..9. Unused bits and unmapped offsets read 0, and `cfg_rdata` reflects `cfg_addr` combinationally.
- R4: A sequence starts on the clock edge that accepts a start-of-packet beat, but only when the disable bit is 0, the count is nonzero and no sequence is running. Otherwise no write is issued.
- R5: A sequence issues exactly min(count, 10) writes, from pair 0 upward in order.
- R6: While `wr_wait` is 1, `wr_req` stays 1 and `wr_addr`/`wr_data` stay stable. The sequence advances only on an edge where `wr_wait` is 0.
- R7: The pairs and the count are captured at the trigger. Register writes during a running sequence do not change the writes it issues.
- R8: A start-of-packet beat accepted while a sequence runs is ignored. The sequence neither restarts nor fires again, and the disable bit is not set by it.
- R9: The last accepted write sets the completion flag. Writing 1 to offset 2 bit 1 clears it, and writing 0 to that bit leaves it set. If a set and a clear arrive together, the set wins.
- R10: `irq` is 1 exactly when the completion flag and the interrupt enable are both 1.
- R11: With `AUTO_DISARM` set (default), the disable bit becomes 1 on the edge after a trigger fires.
- R12: `rst_n` low resets asynchronously. Afterwards all registers read 0, `wr_req` and `irq` are 0, and `s_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| s_data | input | DATA_W | Input stream data |
| s_valid | input | 1 | Input beat valid |
| s_sop | input | 1 | Input start-of-packet marker |
| s_eop | input | 1 | Input end-of-packet marker |
| s_ready | output | 1 | Block accepts an input beat |
| m_data | output | DATA_W | Output stream data |
| m_valid | output | 1 | Output beat valid |
| m_sop | output | 1 | Output start-of-packet marker |
| m_eop | output | 1 | Output end-of-packet marker |
| m_ready | input | 1 | Downstream accepts a beat |
| cfg_addr | input | OFF_W | Register word offset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| irq | output | 1 | Completion interrupt |
| wr_req | output | 1 | Master write request |
| wr_addr | output | 32 | Master write address |
| wr_data | output | 32 | Master write data |
| wr_wait | input | 1 | Fabric stalls the current write |

## Verification
The assertions check on every cycle that a stalled write holds its request, address and data, and that the write index stays below the captured count. They also check that a trigger leaves the sequencer busy at pair 0, and that a start beat arriving mid-sequence only lets the index advance. Completion setting the flag, the automatic disarm and Go preceding every packet entry are checked every cycle too. What only the bench scenarios can show is the content and order of the write list. These scenarios also cover count clamping, shadow isolation from mid-sequence register writes, and the stream gate's behaviour around packet boundaries. The register map decode and the interplay of enable and flag at the interrupt pin are likewise shown only there.

// File: rtl/fws_pkg.sv
package fws_pkg;
  localparam int REG_W     = 32;
  localparam int OFF_CTRL  = 0;
  localparam int OFF_STAT  = 1;
  localparam int OFF_IRQ   = 2;
  localparam int OFF_DIS   = 3;
  localparam int OFF_CNT   = 4;
  localparam int OFF_PAIR0 = 5;
  typedef logic [REG_W-1:0] word_t;
endpackage

// File: rtl/fws_regfile.sv
module fws_regfile #(
  parameter int NUM_PAIRS   = 10,
  parameter int OFF_W       = 5,
  parameter bit AUTO_DISARM = 1'b1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [OFF_W-1:0]                  cfg_addr,
  input  logic                              cfg_wr,
  input  fws_pkg::word_t                    cfg_wdata,
  output fws_pkg::word_t                    cfg_rdata,
  input  logic                              busy,
  input  logic                              done,
  input  logic                              fire,
  output logic                              go,
  output logic                              irq_en,
  output logic                              trig_dis,
  output logic                              irq_flag,
  output fws_pkg::word_t                    wr_count,
  output fws_pkg::word_t [NUM_PAIRS-1:0]    pair_addr,
  output fws_pkg::word_t [NUM_PAIRS-1:0]    pair_data
);
  import fws_pkg::*;

  logic [1:0]               ctrl_q, ctrl_d;
  logic                     dis_q, dis_d;
  logic                     flag_q, flag_d;
  word_t                    cnt_q, cnt_d;
  word_t [NUM_PAIRS-1:0]    pa_q, pa_d, pd_q, pd_d;

  // next state
  always_comb begin
    ctrl_d = ctrl_q;
    dis_d  = dis_q;
    flag_d = flag_q;
    cnt_d  = cnt_q;
    pa_d   = pa_q;
    pd_d   = pd_q;
    if (cfg_wr && cfg_addr == OFF_W'(OFF_CTRL)) ctrl_d = cfg_wdata[1:0];
    if (cfg_wr && cfg_addr == OFF_W'(OFF_DIS))  dis_d  = cfg_wdata[0];
    if (cfg_wr && cfg_addr == OFF_W'(OFF_CNT))  cnt_d  = cfg_wdata;
    if (AUTO_DISARM && fire)                    dis_d  = 1'b1;
    if (cfg_wr && cfg_addr == OFF_W'(OFF_IRQ) && cfg_wdata[1]) flag_d = 1'b0;
    if (done)                                   flag_d = 1'b1;
    for (int k = 0; k < NUM_PAIRS; k++) begin
      if (cfg_wr && cfg_addr == OFF_W'(OFF_PAIR0 + 2*k))     pa_d[k] = cfg_wdata;
      if (cfg_wr && cfg_addr == OFF_W'(OFF_PAIR0 + 2*k + 1)) pd_d[k] = cfg_wdata;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dis_q  <= 1'b0;
      flag_q <= 1'b0;
      cnt_q  <= '0;
      pa_q   <= '0;
      pd_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      dis_q  <= dis_d;
      flag_q <= flag_d;
      cnt_q  <= cnt_d;
      pa_q   <= pa_d;
      pd_q   <= pd_d;
    end
  end

  // read decode
  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == OFF_W'(OFF_CTRL)) cfg_rdata[1:0] = ctrl_q;
    if (cfg_addr == OFF_W'(OFF_STAT)) cfg_rdata[0]   = busy;
    if (cfg_addr == OFF_W'(OFF_IRQ))  cfg_rdata[1]   = flag_q;
    if (cfg_addr == OFF_W'(OFF_DIS))  cfg_rdata[0]   = dis_q;
    if (cfg_addr == OFF_W'(OFF_CNT))  cfg_rdata      = cnt_q;
    for (int k = 0; k < NUM_PAIRS; k++) begin
      if (cfg_addr == OFF_W'(OFF_PAIR0 + 2*k))     cfg_rdata = pa_q[k];
      if (cfg_addr == OFF_W'(OFF_PAIR0 + 2*k + 1)) cfg_rdata = pd_q[k];
    end
  end

  assign go        = ctrl_q[0];
  assign irq_en    = ctrl_q[1];
  assign trig_dis  = dis_q;
  assign irq_flag  = flag_q;
  assign wr_count  = cnt_q;
  assign pair_addr = pa_q;
  assign pair_data = pd_q;

  // R9: completion always leaves the flag set
  a_r9_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag_q);

  generate
    if (AUTO_DISARM) begin : g_disarm_chk
      // R11: a fired trigger disarms itself
      a_r11_auto_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> dis_q);
    end
  endgenerate
endmodule

// File: rtl/fws_stream.sv
module fws_stream #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_sop,
  input  logic              s_eop,
  output logic              s_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_valid,
  output logic              m_sop,
  output logic              m_eop,
  input  logic              m_ready,
  output logic              sof
);
  logic in_pkt_q, in_pkt_d;
  logic gate, accept;

  // a packet in flight keeps the gate open; Go only acts between packets
  assign gate    = in_pkt_q | go;
  assign s_ready = m_ready & gate;
  assign m_valid = s_valid & gate;
  assign m_data  = s_data;
  assign m_sop   = s_sop;
  assign m_eop   = s_eop;
  assign accept  = s_valid & s_ready;
  assign sof     = accept & s_sop;

  always_comb begin
    in_pkt_d = in_pkt_q;
    if (accept) begin
      if (s_eop)      in_pkt_d = 1'b0;
      else if (s_sop) in_pkt_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_pkt_q <= 1'b0;
    else        in_pkt_q <= in_pkt_d;
  end

  // R2: a packet can only be entered while Go is set
  a_r2_entry_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_pkt_q) |-> $past(go));
endmodule

// File: rtl/fws_master.sv
module fws_master #(
  parameter int NUM_PAIRS = 10,
  parameter int CNT_W     = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              sof,
  input  logic                              trig_dis,
  input  fws_pkg::word_t                    wr_count,
  input  fws_pkg::word_t [NUM_PAIRS-1:0]    pair_addr,
  input  fws_pkg::word_t [NUM_PAIRS-1:0]    pair_data,
  input  logic                              wr_wait,
  output logic                              wr_req,
  output fws_pkg::word_t                    wr_addr,
  output fws_pkg::word_t                    wr_data,
  output logic                              busy,
  output logic                              done,
  output logic                              fire
);
  import fws_pkg::*;

  logic                     busy_q, busy_d;
  logic [CNT_W-1:0]         idx_q, idx_d, cnt_q, cnt_d, cnt_clamp;
  word_t [NUM_PAIRS-1:0]    sa_q, sa_d, sd_q, sd_d;
  logic                     last;

  assign cnt_clamp = (wr_count > word_t'(NUM_PAIRS)) ? CNT_W'(NUM_PAIRS)
                                                     : wr_count[CNT_W-1:0];
  assign fire  = sof & ~trig_dis & (wr_count != '0) & ~busy_q;
  assign last  = (idx_q == cnt_q - CNT_W'(1));
  assign done  = busy_q & ~wr_wait & last;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    cnt_d  = cnt_q;
    sa_d   = sa_q;
    sd_d   = sd_q;
    if (fire) begin
      busy_d = 1'b1;
      idx_d  = '0;
      cnt_d  = cnt_clamp;
      sa_d   = pair_addr;
      sd_d   = pair_data;
    end else if (busy_q && !wr_wait) begin
      if (last) busy_d = 1'b0;
      else      idx_d  = idx_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
      sa_q   <= '0;
      sd_q   <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
      sa_q   <= sa_d;
      sd_q   <= sd_d;
    end
  end

  assign wr_req  = busy_q;
  assign busy    = busy_q;
  assign wr_addr = sa_q[idx_q];
  assign wr_data = sd_q[idx_q];

  // R6: a stalled write is held unchanged
  a_r6_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_wait) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));
  // R5: the index never passes the captured count
  a_r5_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q < cnt_q));
  // R4: a trigger starts at pair 0
  a_r4_fire_starts: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (busy_q && idx_q == '0));
  // R8: a frame start during a sequence does not restart it
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && sof && !wr_wait && !last) |=> (idx_q == $past(idx_q) + CNT_W'(1)));
endmodule

// File: rtl/frame_wr_sequencer.sv
module frame_wr_sequencer #(
  parameter int DATA_W      = 24,
  parameter int NUM_PAIRS   = 10,
  parameter bit AUTO_DISARM = 1'b1,
  localparam int OFF_W      = $clog2(fws_pkg::OFF_PAIR0 + 2*NUM_PAIRS),
  localparam int CNT_W      = $clog2(NUM_PAIRS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_sop,
  input  logic              s_eop,
  output logic              s_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              m_valid,
  output logic              m_sop,
  output logic              m_eop,
  input  logic              m_ready,
  input  logic [OFF_W-1:0]  cfg_addr,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              irq,
  output logic              wr_req,
  output logic [31:0]       wr_addr,
  output logic [31:0]       wr_data,
  input  logic              wr_wait
);
  import fws_pkg::*;

  logic                     go, irq_en, trig_dis, irq_flag;
  logic                     sof, busy, done, fire;
  word_t                    wr_count;
  word_t [NUM_PAIRS-1:0]    pair_addr, pair_data;

  fws_regfile #(.NUM_PAIRS(NUM_PAIRS), .OFF_W(OFF_W), .AUTO_DISARM(AUTO_DISARM)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy), .done(done),
    .fire(fire), .go(go), .irq_en(irq_en), .trig_dis(trig_dis),
    .irq_flag(irq_flag), .wr_count(wr_count), .pair_addr(pair_addr),
    .pair_data(pair_data)
  );

  fws_stream #(.DATA_W(DATA_W)) u_stream (
    .clk(clk), .rst_n(rst_n), .go(go), .s_data(s_data), .s_valid(s_valid),
    .s_sop(s_sop), .s_eop(s_eop), .s_ready(s_ready), .m_data(m_data),
    .m_valid(m_valid), .m_sop(m_sop), .m_eop(m_eop), .m_ready(m_ready),
    .sof(sof)
  );

  fws_master #(.NUM_PAIRS(NUM_PAIRS), .CNT_W(CNT_W)) u_master (
    .clk(clk), .rst_n(rst_n), .sof(sof), .trig_dis(trig_dis),
    .wr_count(wr_count), .pair_addr(pair_addr), .pair_data(pair_data),
    .wr_wait(wr_wait), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .fire(fire)
  );

  assign irq = irq_flag & irq_en;
endmodule

// File: tb/frame_wr_sequencer_tb.sv
`timescale 1ns/1ps
module frame_wr_sequencer_tb;
  localparam int DATA_W = 24;
  localparam int NP     = 10;

  logic              clk, rst_n;
  logic [DATA_W-1:0] s_data, m_data;
  logic              s_valid, s_sop, s_eop, s_ready;
  logic              m_valid, m_sop, m_eop, m_ready;
  logic [4:0]        cfg_addr;
  logic              cfg_wr;
  logic [31:0]       cfg_wdata, cfg_rdata;
  logic              irq, wr_req, wr_wait;
  logic [31:0]       wr_addr, wr_data;

  frame_wr_sequencer #(.DATA_W(DATA_W), .NUM_PAIRS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid),
    .s_sop(s_sop), .s_eop(s_eop), .s_ready(s_ready), .m_data(m_data),
    .m_valid(m_valid), .m_sop(m_sop), .m_eop(m_eop), .m_ready(m_ready),
    .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq(irq), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_wait(wr_wait)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int mon_n  = 0;
  logic [31:0] mon_a [64];
  logic [31:0] mon_d [64];

  // record accepted master writes mid-cycle
  always @(negedge clk) begin
    if (rst_n && wr_req && !wr_wait) begin
      if (mon_n < 64) begin
        mon_a[mon_n] = wr_addr;
        mon_d[mon_n] = wr_data;
      end
      mon_n = mon_n + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    cfg_addr = a; #1;
    d = cfg_rdata;
  endtask

  task automatic beat(input logic sop, input logic eop, input logic [DATA_W-1:0] d);
    @(posedge clk); #1;
    s_valid = 1'b1; s_sop = sop; s_eop = eop; s_data = d;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    @(posedge clk); #1;
    s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && wr_req; i++) @(negedge clk);
  endtask

  typedef struct packed {
    logic [4:0]  off;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  // R3: register map write/read-back vectors
  localparam vec_t VECS [11] = '{
    '{5'd0,  32'hFFFF_FFFE, 32'h0000_0002},
    '{5'd1,  32'hFFFF_FFFF, 32'h0000_0000},
    '{5'd3,  32'h0000_0001, 32'h0000_0001},
    '{5'd3,  32'hFFFF_FFFE, 32'h0000_0000},
    '{5'd4,  32'h0000_0007, 32'h0000_0007},
    '{5'd5,  32'h0000_1000, 32'h0000_1000},
    '{5'd6,  32'hDEAD_BEEF, 32'hDEAD_BEEF},
    '{5'd24, 32'h0A0A_0A0A, 32'h0A0A_0A0A},
    '{5'd25, 32'hFFFF_FFFF, 32'h0000_0000},
    '{5'd2,  32'hFFFF_FFFF, 32'h0000_0000},
    '{5'd0,  32'h0000_0000, 32'h0000_0000}
  };

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int base;
    rst_n = 1'b0; s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0; s_data = '0;
    m_ready = 1'b1; cfg_addr = '0; cfg_wr = 1'b0; cfg_wdata = '0; wr_wait = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    check("R12 s_ready", {31'd0, s_ready}, 32'd0);
    check("R12 wr_req", {31'd0, wr_req}, 32'd0);
    check("R12 irq", {31'd0, irq}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    rd(5'd0, r); check("R12 ctrl", r, 32'd0);
    rd(5'd3, r); check("R12 disable", r, 32'd0);

    // R3: table walk
    foreach (VECS[i]) begin
      wr(VECS[i].off, VECS[i].wd);
      rd(VECS[i].off, r);
      check($sformatf("R3 vec %0d", i), r, VECS[i].exp);
    end

    // R1: pass-through with count 0 so nothing triggers
    wr(5'd4, 32'd0);
    wr(5'd0, 32'd1);
    s_valid = 1'b1; s_data = 24'h123456; s_eop = 1'b1; #1;
    check("R1 m_valid", {31'd0, m_valid}, 32'd1);
    check("R1 m_data", {8'd0, m_data}, 32'h0012_3456);
    check("R1 m_eop", {31'd0, m_eop}, 32'd1);
    check("R1 s_ready", {31'd0, s_ready}, 32'd1);
    m_ready = 1'b0; #1;
    check("R1 s_ready follows m_ready", {31'd0, s_ready}, 32'd0);
    m_ready = 1'b1; s_valid = 1'b0; s_eop = 1'b0;

    // R2: gate closed between packets
    wr(5'd0, 32'd0);
    s_valid = 1'b1; #1;
    check("R2 m_valid closed", {31'd0, m_valid}, 32'd0);
    check("R2 s_ready closed", {31'd0, s_ready}, 32'd0);
    s_valid = 1'b0;
    // R2: packet in flight survives Go clear
    wr(5'd0, 32'd1);
    beat(1'b1, 1'b0, 24'h000001);
    wr(5'd0, 32'd0);
    #1;
    check("R2 in-packet s_ready", {31'd0, s_ready}, 32'd1);
    beat(1'b0, 1'b1, 24'h000002);
    #1;
    check("R2 closed after eop", {31'd0, s_ready}, 32'd0);

    // program ten pairs
    for (int k = 0; k < NP; k++) begin
      wr(5'(5 + 2*k), 32'h100 + 32'(4*k));
      wr(5'(6 + 2*k), 32'hA0 + 32'(k));
    end

    // R4/R5/R6/R7/R9/R10/R11: main sequence with stall
    wr(5'd4, 32'd3);
    wr(5'd0, 32'd3);
    wr(5'd3, 32'd0);
    wr_wait = 1'b1;
    base = mon_n;
    beat(1'b1, 1'b0, 24'h0000AA);
    #1;
    check("R4 wr_req after trigger", {31'd0, wr_req}, 32'd1);
    rd(5'd1, r); check("R3 status busy", r, 32'd1);
    wr(5'd5, 32'h0000_FFFF);
    wr(5'd4, 32'd1);
    repeat (3) @(negedge clk);
    check("R6 addr held", wr_addr, 32'h100);
    check("R6 no write under wait", 32'(mon_n - base), 32'd0);
    @(posedge clk); #1; wr_wait = 1'b0;
    wait_idle();
    check("R5 R7 write count", 32'(mon_n - base), 32'd3);
    for (int k = 0; k < 3; k++) begin
      check($sformatf("R5 R7 addr %0d", k), mon_a[base + k], 32'h100 + 32'(4*k));
      check($sformatf("R5 data %0d", k), mon_d[base + k], 32'hA0 + 32'(k));
    end
    #1;
    check("R10 irq set", {31'd0, irq}, 32'd1);
    rd(5'd2, r); check("R9 flag", r, 32'd2);
    rd(5'd3, r); check("R11 disarmed", r, 32'd1);
    rd(5'd1, r); check("R3 status idle", r, 32'd0);
    wr(5'd2, 32'd1); #1;
    check("R9 write 0 to bit1 keeps flag", {31'd0, irq}, 32'd1);
    wr(5'd2, 32'd2); #1;
    check("R9 clear", {31'd0, irq}, 32'd0);
    beat(1'b0, 1'b1, 24'h0000BB);

    // R4: disabled trigger
    base = mon_n;
    beat(1'b1, 1'b1, 24'h000011);
    repeat (20) @(negedge clk);
    check("R4 disabled no writes", 32'(mon_n - base), 32'd0);
    // R4: zero count
    wr(5'd3, 32'd0);
    wr(5'd4, 32'd0);
    beat(1'b1, 1'b1, 24'h000012);
    repeat (20) @(negedge clk);
    check("R4 zero count no writes", 32'(mon_n - base), 32'd0);

    // R5: clamp to ten, R10 enable off
    wr(5'd5, 32'h100);
    wr(5'd4, 32'd15);
    wr(5'd0, 32'd1);
    base = mon_n;
    beat(1'b1, 1'b1, 24'h000013);
    wait_idle();
    check("R5 clamp count", 32'(mon_n - base), 32'd10);
    check("R5 last addr", mon_a[base + 9], 32'h124);
    check("R5 first addr", mon_a[base], 32'h100);
    #1;
    check("R10 irq masked", {31'd0, irq}, 32'd0);
    rd(5'd2, r); check("R10 flag still set", r, 32'd2);

    // R8: start beat during running sequence
    wr(5'd2, 32'd2);
    wr(5'd4, 32'd2);
    wr(5'd3, 32'd0);
    wr_wait = 1'b1;
    base = mon_n;
    beat(1'b1, 1'b1, 24'h000014);
    wr(5'd3, 32'd0);
    beat(1'b1, 1'b1, 24'h000015);
    #1;
    rd(5'd3, r); check("R8 second start did not fire", r, 32'd0);
    @(posedge clk); #1; wr_wait = 1'b0;
    wait_idle();
    repeat (10) @(negedge clk);
    check("R8 one sequence only", 32'(mon_n - base), 32'd2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule